// File: doc/BRIEF.md
# NAND Single-Bit Hamming Code Engine

This block builds a 24-bit Hamming-style check code over one data chunk of a NAND page (512 bytes by default), taking one byte per cycle from a byte stream. Each data bit has a 12-bit bit address made of its byte index (9 bits) and its bit position in the byte (3 bits). For each address bit the engine keeps two parities: one over the data bits whose address bit is 1 and one over those whose address bit is 0. These two 12-bit halves are packed into 24 bits and inverted. As a result, an erased chunk (all 0xFF) yields an all-ones code, which is what an erased spare area holds.

Several chip selects can each own an accumulation context. A start pulse for one context clears it and arms it. Bytes tagged with that context's select are then folded in. A read request on a context returns its packed code and, in the same response, the result of comparing it with a stored code supplied with the request. The comparison reports one of four outcomes: no error, a correctable data-bit error with its byte and bit, a single flipped bit inside the code, or an uncorrectable error. The read also clears and disarms the context.

Top module: `nand_hecc_engine`

## Requirements
- R1: After reset no result is flagged (`res_valid` = 0), and every context is empty and disarmed. A read of any context then returns code 0xFFFFFF.
- R2: A data bit at address A = {byte index, bit position} toggles the upper raw half at the positions where A is 1 and the lower raw half at the positions where A is 0. The code is the bitwise inverse of {upper half, lower half}.
- R3: A chunk of CHUNK_BYTES bytes that are all 0xFF gives code 0xFFFFFF.
- R4: A byte is folded only into the context whose index equals `in_cs`, and only while that context is armed. Other contexts and disarmed contexts are unchanged.
- R5: Bytes past the first CHUNK_BYTES since a start are ignored.
- R6: A read request yields `res_valid` exactly one cycle later, carrying the code that was accumulated before the request. It leaves the context empty and disarmed, so bytes sent before the next start have no effect.
- R7: A start pulse empties and arms its context. A byte to the same context in the same cycle is dropped.
- R8: With diff = calculated code XOR stored code, a zero diff gives `res_kind` 0 (no error).
- R9: If diff[23:12] XOR diff[11:0] is 0xFFF and diff[23:15] < CHUNK_BYTES, then `res_kind` is 1 (data error), `res_byte` = diff[23:15] and `res_bit` = diff[14:12].
- R10: A diff with complementary halves whose byte index diff[23:15] is CHUNK_BYTES or more gives `res_kind` 3 (uncorrectable).
- R11: A diff with exactly one bit set gives `res_kind` 2 (code-bit error).
- R12: Any other nonzero diff gives `res_kind` 3. `res_byte` and `res_bit` are zero whenever `res_kind` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | NUM_CS | One start pulse per context |
| in_valid | input | 1 | Data byte present |
| in_cs | input | CS_W | Context the data byte belongs to |
| in_byte | input | 8 | Data byte |
| rd_req | input | 1 | Read and compare request |
| rd_cs | input | CS_W | Context to read |
| stored_code | input | 24 | Code previously stored for the chunk |
| res_valid | output | 1 | Result present (one cycle) |
| res_code | output | 24 | Calculated packed, inverted code |
| res_kind | output | 2 | 0 none, 1 data bit, 2 code bit, 3 uncorrectable |
| res_byte | output | 9 | Byte index of a data-bit error |
| res_bit | output | 3 | Bit position of a data-bit error |

## Verification
A byte driven in one cycle changes the context register at the next edge. A read request raises `res_valid` on the edge after it is driven, and the code and outcome are registered on that same edge. The bench drives each stimulus on a falling edge and samples the result on the following falling edge, which is the only cycle where `res_valid` is high. Expected codes come from a bit-by-bit model that loops over the data. Expected outcomes come from the error that was injected into the stored code, never from the design's own classifier.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;
  localparam int HALF_W  = 12;
  localparam int CODE_W  = 2 * HALF_W;
  localparam int HI_LSB  = 16;
  localparam int RAW_W   = HI_LSB + HALF_W;
  localparam int BIT_AW  = 3;
  localparam int BYTE_AW = HALF_W - BIT_AW;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_CODE   = 2'd2,
    KIND_UNCORR = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [BYTE_AW-1:0]  byte_idx;
    logic [BIT_AW-1:0]   bit_idx;
  } verdict_t;

  // Raw-layout parity contribution of one byte at index idx.
  function automatic logic [RAW_W-1:0] byte_contrib(input logic [BYTE_AW-1:0] idx,
                                                    input logic [7:0] data);
    logic [HALF_W-1:0] hi_half;
    logic [HALF_W-1:0] lo_half;
    logic [RAW_W-1:0]  r;
    hi_half = '0;
    lo_half = '0;
    for (int j = 0; j < 8; j++) begin
      if (data[j]) begin
        hi_half ^=  {idx, BIT_AW'(j)};
        lo_half ^= ~{idx, BIT_AW'(j)};
      end
    end
    r = '0;
    r[HI_LSB +: HALF_W] = hi_half;
    r[HALF_W-1:0]       = lo_half;
    return r;
  endfunction

  // Pack the two raw halves into the 24-bit inverted code.
  function automatic logic [CODE_W-1:0] pack_code(input logic [HALF_W-1:0] hi_half,
                                                  input logic [HALF_W-1:0] lo_half);
    return ~{hi_half, lo_half};
  endfunction
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
  import nand_hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic             take,
  input  logic [7:0]       data,
  output logic [RAW_W-1:0] raw,
  output logic             armed
);
  localparam int CNT_W = $clog2(CHUNK_BYTES + 1);

  logic [CNT_W-1:0] cnt;
  logic             room;
  logic             fold;

  assign room = (cnt < CNT_W'(CHUNK_BYTES));
  assign fold = take && armed && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw   <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      raw   <= '0;
      cnt   <= '0;
      armed <= 1'b1;
    end else if (clear) begin
      raw   <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (fold) begin
      raw <= raw ^ byte_contrib(BYTE_AW'(cnt), data);
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CHUNK_BYTES)); // R5
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> armed && cnt == '0 && raw == '0); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !start |=> $stable(raw)); // R4
  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !start |=> !armed && raw == '0); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !room && !start && !clear |=> $stable(raw)); // R5
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import nand_hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output verdict_t          verdict
);
  logic [CODE_W-1:0]  diff;
  logic               halves_comp;
  logic               single_bit;
  logic [BYTE_AW-1:0] loc_byte;
  logic               in_chunk;

  assign diff        = calc ^ stored;
  assign halves_comp = ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}});
  assign single_bit  = ($countones(diff) == 1);
  assign loc_byte    = diff[CODE_W-1:HALF_W+BIT_AW];
  assign in_chunk    = ({1'b0, loc_byte} < (BYTE_AW+1)'(CHUNK_BYTES));

  always_comb begin
    verdict = '0;
    if (diff == '0) begin
      verdict.kind = KIND_NONE;
    end else if (halves_comp) begin
      if (in_chunk) begin
        verdict.kind     = KIND_DATA;
        verdict.byte_idx = loc_byte;
        verdict.bit_idx  = diff[HALF_W+BIT_AW-1:HALF_W];
      end else begin
        verdict.kind = KIND_UNCORR;
      end
    end else if (single_bit) begin
      verdict.kind = KIND_CODE;
    end else begin
      verdict.kind = KIND_UNCORR;
    end
  end
endmodule

// File: rtl/nand_hecc_engine.sv
module nand_hecc_engine
  import nand_hecc_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int CHUNK_BYTES = 512,
  localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] start,
  input  logic              in_valid,
  input  logic [CS_W-1:0]   in_cs,
  input  logic [7:0]        in_byte,
  input  logic              rd_req,
  input  logic [CS_W-1:0]   rd_cs,
  input  logic [23:0]       stored_code,
  output logic              res_valid,
  output logic [23:0]       res_code,
  output logic [1:0]        res_kind,
  output logic [8:0]        res_byte,
  output logic [2:0]        res_bit
);
  logic [RAW_W-1:0] ctx_raw [NUM_CS];
  logic [NUM_CS-1:0] ctx_armed;
  logic [RAW_W-1:0] sel_raw;
  logic [CODE_W-1:0] calc_code;
  verdict_t          verdict;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ctx
    logic take_i;
    logic clear_i;
    assign take_i  = in_valid && (in_cs == CS_W'(i));
    assign clear_i = rd_req && (rd_cs == CS_W'(i));
    hecc_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start[i]),
      .clear (clear_i),
      .take  (take_i),
      .data  (in_byte),
      .raw   (ctx_raw[i]),
      .armed (ctx_armed[i])
    );
  end

  always_comb begin
    sel_raw = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_cs == CS_W'(i)) sel_raw = ctx_raw[i];
    end
  end

  assign calc_code = pack_code(sel_raw[HI_LSB +: HALF_W], sel_raw[HALF_W-1:0]);

  hecc_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_classify (
    .calc    (calc_code),
    .stored  (stored_code),
    .verdict (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= '0;
      res_kind  <= '0;
      res_byte  <= '0;
      res_bit   <= '0;
    end else begin
      res_valid <= rd_req;
      if (rd_req) begin
        res_code <= calc_code;
        res_kind <= verdict.kind;
        res_byte <= verdict.byte_idx;
        res_bit  <= verdict.bit_idx;
      end
    end
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> res_valid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !res_valid); // R6
  AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> sel_raw[HI_LSB-1:HALF_W] == '0); // R2
  AST_LOC_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != KIND_DATA |-> res_byte == '0 && res_bit == '0); // R12
  AST_DATA_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == KIND_DATA |-> {1'b0, res_byte} < 10'(CHUNK_BYTES)); // R10
  AST_CODE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> res_kind != KIND_CODE || $countones(res_code ^ $past(stored_code)) == 1); // R11
  AST_NONE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> res_kind != KIND_NONE || res_code == $past(stored_code)); // R8
endmodule

// File: tb/test_nand_hecc_engine.sv
module test_nand_hecc_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  start = '0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_cs = '0;
  logic [7:0]  in_byte = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic [23:0] stored_code = '0;
  logic        res_valid;
  logic [23:0] res_code;
  logic [1:0]  res_kind;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;

  nand_hecc_engine i_nand_hecc_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_cs(in_cs),
    .in_byte(in_byte), .rd_req(rd_req), .rd_cs(rd_cs), .stored_code(stored_code),
    .res_valid(res_valid), .res_code(res_code), .res_kind(res_kind),
    .res_byte(res_byte), .res_bit(res_bit));

  // Second instance with a 256-byte chunk, for the out-of-range location case.
  logic        h_start = 1'b0;
  logic        h_rd = 1'b0;
  logic [23:0] h_stored = '0;
  logic        h_valid;
  logic [23:0] h_code;
  logic [1:0]  h_kind;
  logic [8:0]  h_byte;
  logic [2:0]  h_bit;

  nand_hecc_engine #(.NUM_CS(1), .CHUNK_BYTES(256)) i_nand_hecc_engine_half (
    .clk(clk), .rst_n(rst_n), .start(h_start), .in_valid(1'b0), .in_cs(1'b0),
    .in_byte(8'h00), .rd_req(h_rd), .rd_cs(1'b0), .stored_code(h_stored),
    .res_valid(h_valid), .res_code(h_code), .res_kind(h_kind),
    .res_byte(h_byte), .res_bit(h_bit));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] dbuf [0:599];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-by-bit model of the code over the first len bytes of dbuf (capped at 512).
  function automatic logic [23:0] model_code(input int len);
    logic [11:0] up = '0;
    logic [11:0] dn = '0;
    int lim = (len < 512) ? len : 512;
    for (int n = 0; n < lim; n++)
      for (int b = 0; b < 8; b++)
        if (dbuf[n][b])
          for (int k = 0; k < 12; k++) begin
            logic [11:0] a = 12'(n * 8 + b);
            if (a[k]) up[k] = ~up[k];
            else      dn[k] = ~dn[k];
          end
    return ~{up, dn};
  endfunction

  task automatic do_start(input int c);
    @(negedge clk); start = 4'b0001 << c;
    @(negedge clk); start = '0;
  endtask

  task automatic stream(input int c, input int len);
    for (int n = 0; n < len; n++) begin
      @(negedge clk); in_valid = 1'b1; in_cs = 2'(c); in_byte = dbuf[n];
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic do_read(input string tag, input int c, input logic [23:0] st,
                         input logic [23:0] exp_code, input logic [1:0] exp_kind,
                         input logic [8:0] exp_byte, input logic [2:0] exp_bit);
    @(negedge clk); rd_req = 1'b1; rd_cs = 2'(c); stored_code = st;
    @(negedge clk); rd_req = 1'b0;
    chk({tag, " R6 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " code"}, 32'(res_code), 32'(exp_code));
    chk({tag, " kind"}, 32'(res_kind), 32'(exp_kind));
    chk({tag, " byte"}, 32'(res_byte), 32'(exp_byte));
    chk({tag, " bit"},  32'(res_bit),  32'(exp_bit));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] code;
    logic [11:0] a;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no result after reset", 32'(res_valid), 32'd0);
    do_read("R1 empty ctx0", 0, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);

    // R3: erased chunk, R8 matching code
    for (int n = 0; n < 512; n++) dbuf[n] = 8'hFF;
    do_start(1); stream(1, 512);
    do_read("R3 R8 erased", 1, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);

    // R2: single set bit at byte 0 bit 0
    dbuf[0] = 8'h01;
    do_start(0); stream(0, 1);
    do_read("R2 one bit at 0", 0, 24'hFFF000, 24'hFFF000, 2'd0, 9'd0, 3'd0);

    // R2 R9: byte 5 = 0x80, stored code as if data was clean
    for (int n = 0; n < 8; n++) dbuf[n] = 8'h00;
    dbuf[5] = 8'h80;
    code = model_code(8);
    do_start(2); stream(2, 8);
    do_read("R9 data bit", 2, 24'hFFFFFF, code, 2'd1, 9'd5, 3'd7);

    // Random chunks with injected errors
    for (int it = 0; it < 8; it++) begin
      int c = it % 4;
      int mode = it % 4;
      logic [23:0] st;
      logic [1:0]  ek = 2'd0;
      logic [8:0]  eb = '0;
      logic [2:0]  ei = '0;
      for (int n = 0; n < 512; n++) dbuf[n] = 8'($urandom);
      code = model_code(512);
      st = code;
      if (mode == 1) begin
        eb = 9'($urandom % 512); ei = 3'($urandom);
        a = {eb, ei};
        st = code ^ {a, ~a}; ek = 2'd1;
      end else if (mode == 2) begin
        st = code ^ (24'd1 << ($urandom % 24)); ek = 2'd2;
      end else if (mode == 3) begin
        int p = $urandom % 24;
        int q = (p + 1 + ($urandom % 23)) % 24;
        st = code ^ (24'd1 << p) ^ (24'd1 << q); ek = 2'd3;
      end
      do_start(c); stream(c, 512);
      do_read($sformatf("R2 R8 R9 R11 R12 random it%0d", it), c, st, code, ek, eb, ei);
    end

    // R4: bytes to a disarmed context do not reach it or an armed neighbour
    for (int n = 0; n < 5; n++) dbuf[n] = 8'hA5;
    do_start(2); stream(1, 5);
    do_read("R4 armed neighbour", 2, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);
    do_read("R4 disarmed ctx", 1, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);

    // R5: bytes beyond the chunk are ignored
    for (int n = 0; n < 520; n++) dbuf[n] = 8'($urandom);
    code = model_code(520);
    do_start(3); stream(3, 520);
    do_read("R5 overlong", 3, code, code, 2'd0, 9'd0, 3'd0);

    // R6: read cleared and disarmed the context
    stream(3, 3);
    do_read("R6 after read", 3, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);

    // R7: start wins over a same-cycle byte
    @(negedge clk); start = 4'b0001; in_valid = 1'b1; in_cs = 2'd0; in_byte = 8'h01;
    @(negedge clk); start = '0; in_valid = 1'b0;
    do_read("R7 start drops byte", 0, 24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0, 3'd0);

    // R12: uncorrectable diff of three bits
    do_start(0);
    do_read("R12 three bits", 0, 24'hFFFFF8, 24'hFFFFFF, 2'd3, 9'd0, 3'd0);

    // R10: location beyond a 256-byte chunk
    @(negedge clk); h_start = 1'b1;
    @(negedge clk); h_start = 1'b0;
    a = {9'd300, 3'd2};
    @(negedge clk); h_rd = 1'b1; h_stored = 24'hFFFFFF ^ {a, ~a};
    @(negedge clk); h_rd = 1'b0;
    chk("R10 out of chunk kind", 32'(h_kind), 32'd3);
    chk("R10 out of chunk byte", 32'(h_byte), 32'd0);
    a = {9'd100, 3'd6};
    @(negedge clk); h_start = 1'b1;
    @(negedge clk); h_start = 1'b0;
    @(negedge clk); h_rd = 1'b1; h_stored = 24'hFFFFFF ^ {a, ~a};
    @(negedge clk); h_rd = 1'b0;
    chk("R10 in chunk kind", 32'(h_kind), 32'd1);
    chk("R10 in chunk byte", 32'(h_byte), 32'd100);
    chk("R10 in chunk bit", 32'(h_bit), 32'd6);
    chk("R6 half valid", 32'(h_valid), 32'd1);
    chk("R1 half code", 32'(h_code), 32'hFFFFFF);

    if (seed == 32'hFFFF_FFFF) $display("seed wrap");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule